// File: doc/BRIEF.md
# Serial Port Resource Decoder

This block turns the configuration-space settings of two logical serial-port devices into live hardware resources. While software programs the device banks, the block keeps a shadow of the registers it cares about: the enable, the 16-bit base address and the interrupt number of each port. Those settings reach the decoder only when the configuration controller pulses a commit strobe as configuration mode ends.

The commit takes two clock edges. On the first edge every active port whose enable was cleared, or whose base or interrupt number changed, is taken down. On the second edge every inactive port whose enable is set comes up with the new values. A port whose settings did not change stays up throughout.

At run time the block compares each host I/O address against the 8-byte window of every live port. It returns a one-hot chip select and the 3-bit offset within the selected window, and it steers each port's interrupt request onto one of sixteen interrupt lines.

Top module: `sio_serial_res`

## Requirements
- R1: Port 0 owns logical device 4 and port 1 owns logical device 5. Within a device, register 0x30 is the enable, 0x60 is the base high byte, 0x61 is the base low byte, and the low nibble of 0x70 is the interrupt number. Writes to any other device or register change nothing.
- R2: A port comes up only when the last value written to its enable register is nonzero.
- R3: Register writes alone never change the live resources. Only a `cfg_commit` pulse in the idle phase does.
- R4: After a commit edge, an active port whose enable is now zero, or whose base or interrupt number differs, reads inactive for one cycle. If its enable is nonzero it is active with the new values after the next edge. An inactive port with a nonzero enable also comes up on that second edge.
- R5: An active port whose enable, base and interrupt number are all unchanged stays active through both commit edges without a gap.
- R6: `port_cs[p]` is high only when port p is active and base <= io_addr < base+8. The comparison is done without 16-bit wrap, so a window at 0xFFF8 does not reach 0x0000.
- R7: `port_off` equals io_addr minus the base of the selected port, in 3 bits. It is 0 when no port is selected.
- R8: When both windows match, port 0 wins, and at most one chip select bit is ever high.
- R9: `irq_out[n]` for n in 1..15 is the OR of `uart_irq[p]` over the active ports whose interrupt number is n. Number 0 and inactive ports drive no line.
- R10: A commit pulse that arrives during the apply cycle is ignored.
- R11: After reset both ports are inactive, all shadow fields are zero, and no chip select or interrupt line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration data write strobe |
| cfg_dev | input | 8 | Currently selected logical device number |
| cfg_idx | input | 8 | Currently selected register index |
| cfg_data | input | 8 | Data being written |
| cfg_commit | input | 1 | One-cycle pulse on configuration mode exit |
| io_addr | input | 16 | Host I/O address to decode |
| uart_irq | input | 2 | Interrupt request from each port's UART |
| port_cs | output | 2 | One-hot chip select per port |
| port_off | output | 3 | Offset inside the selected window |
| port_active | output | 2 | Live enable flag per port |
| irq_out | output | 16 | Interrupt lines |

## Verification
Two stretches of the two-edge commit get targeted checks. The first is the gap in which a changed port reads inactive: a design that updates in place would skip that gap. The second is the unchanged port that must keep running: a design that tears everything down would blink it off. Windows are swept from four below to eleven above each base. The sweep includes the top of the address space, where a 16-bit wrapping compare would wrongly claim addresses 0x0000 to 0x0007, and overlapping windows, where a design with the wrong priority would select port 1 or both ports. Every pairing of interrupt numbers is tried under all request patterns, so a design that routed number 0, or kept routing a disabled port, would raise a line that must stay low.

// File: rtl/sio_res_pkg.sv
package sio_res_pkg;
    parameter int ADDR_W = 16;
    parameter int IRQ_W  = 4;

    localparam logic [7:0] IDX_ENABLE  = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [IRQ_W-1:0]  irq;
    } port_cfg_t;

    typedef enum logic {PH_IDLE, PH_APPLY} phase_t;
endpackage

// File: rtl/sio_cfg_shadow.sv
module sio_cfg_shadow
    import sio_res_pkg::*;
#(
    parameter int NPORT     = 2,
    parameter int FIRST_DEV = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [7:0]                  dev,
    input  logic [7:0]                  idx,
    input  logic [7:0]                  data,
    output port_cfg_t [NPORT-1:0]       shadow
);
    typedef struct packed {
        port_cfg_t [NPORT-1:0] sh;
    } shadow_st_t;

    shadow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            for (int p = 0; p < NPORT; p++) begin
                if (dev == 8'(FIRST_DEV + p)) begin
                    case (idx)
                        IDX_ENABLE:  st_d.sh[p].en                = |data;
                        IDX_BASE_HI: st_d.sh[p].base[ADDR_W-1:8]  = data[ADDR_W-9:0];
                        IDX_BASE_LO: st_d.sh[p].base[7:0]         = data;
                        IDX_IRQ:     st_d.sh[p].irq               = data[IRQ_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.sh;

    logic own_dev;
    assign own_dev = (int'(dev) >= FIRST_DEV) && (int'(dev) < FIRST_DEV + NPORT);

    // R1: writes to a device this block does not own leave every shadow field untouched
    a_r1_foreign_dev_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !own_dev) |=> $stable(st_q));
endmodule

// File: rtl/sio_commit_ctrl.sv
module sio_commit_ctrl
    import sio_res_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  port_cfg_t [NPORT-1:0] shadow,
    output port_cfg_t [NPORT-1:0] live
);
    typedef struct packed {
        phase_t                phase;
        port_cfg_t [NPORT-1:0] snap;
        port_cfg_t [NPORT-1:0] live;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (commit) begin
                    st_d.snap  = shadow;
                    st_d.phase = PH_APPLY;
                    for (int p = 0; p < NPORT; p++) begin
                        if (st_q.live[p].en &&
                            (!shadow[p].en ||
                             shadow[p].base != st_q.live[p].base ||
                             shadow[p].irq  != st_q.live[p].irq)) begin
                            st_d.live[p].en = 1'b0;
                        end
                    end
                end
            end
            PH_APPLY: begin
                st_d.phase = PH_IDLE;
                for (int p = 0; p < NPORT; p++) begin
                    if (!st_q.live[p].en && st_q.snap[p].en) begin
                        st_d.live[p] = st_q.snap[p];
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = st_q.live;

    // R10: a commit seen while idle always leads into the apply cycle, which returns to idle
    a_r10_apply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && commit) |=> (st_q.phase == PH_APPLY));
    a_r10_apply_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_APPLY) |=> (st_q.phase == PH_IDLE));
    // R3: with no commit in idle, live resources hold
    a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !commit) |=> $stable(st_q.live));

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        // R4: a port only comes up on the apply edge
        a_r4_rise_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.live[g].en) |-> $past(st_q.phase == PH_APPLY));
        // R5: an untouched active port is never dropped by a commit
        a_r5_unchanged_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.phase == PH_IDLE && commit && st_q.live[g].en && shadow[g].en &&
             shadow[g].base == st_q.live[g].base && shadow[g].irq == st_q.live[g].irq)
            |=> st_q.live[g].en);
    end
endmodule

// File: rtl/sio_win_decode.sv
module sio_win_decode
    import sio_res_pkg::*;
#(
    parameter int NPORT = 2,
    parameter int WIN_W = 3
) (
    input  port_cfg_t [NPORT-1:0] live,
    input  logic [ADDR_W-1:0]     io_addr,
    output logic [NPORT-1:0]      cs,
    output logic [WIN_W-1:0]      off
);
    localparam logic [ADDR_W:0] WIN_SPAN = (ADDR_W+1)'(1 << WIN_W);

    logic [NPORT-1:0]             hit;
    logic [NPORT-1:0][ADDR_W-1:0] diff;

    for (genvar g = 0; g < NPORT; g++) begin : g_win
        logic [ADDR_W:0] lo, hi, a;
        assign lo       = {1'b0, live[g].base};
        assign hi       = lo + WIN_SPAN;
        assign a        = {1'b0, io_addr};
        assign hit[g]   = live[g].en && (a >= lo) && (a < hi);
        assign diff[g]  = io_addr - live[g].base;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        cs    = '0;
        off   = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (hit[p] && !found) begin
                cs[p] = 1'b1;
                off   = diff[p][WIN_W-1:0];
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_irq_route.sv
module sio_irq_route
    import sio_res_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  port_cfg_t [NPORT-1:0] live,
    input  logic [NPORT-1:0]      uart_irq,
    output logic [(1<<IRQ_W)-1:0] irq_out
);
    localparam int NLINE = 1 << IRQ_W;

    always_comb begin
        irq_out = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int n = 1; n < NLINE; n++) begin
                if (live[p].en && live[p].irq == IRQ_W'(n) && uart_irq[p]) begin
                    irq_out[n] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sio_serial_res.sv
module sio_serial_res
    import sio_res_pkg::*;
#(
    parameter int NPORT     = 2,
    parameter int FIRST_DEV = 4,
    parameter int WIN_W     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [7:0]               cfg_dev,
    input  logic [7:0]               cfg_idx,
    input  logic [7:0]               cfg_data,
    input  logic                     cfg_commit,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [NPORT-1:0]         uart_irq,
    output logic [NPORT-1:0]         port_cs,
    output logic [WIN_W-1:0]         port_off,
    output logic [NPORT-1:0]         port_active,
    output logic [(1<<IRQ_W)-1:0]    irq_out
);
    port_cfg_t [NPORT-1:0] shadow;
    port_cfg_t [NPORT-1:0] live;

    sio_cfg_shadow #(.NPORT(NPORT), .FIRST_DEV(FIRST_DEV)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dev(cfg_dev),
        .idx(cfg_idx), .data(cfg_data), .shadow(shadow)
    );

    sio_commit_ctrl #(.NPORT(NPORT)) u_commit (
        .clk(clk), .rst_n(rst_n), .commit(cfg_commit),
        .shadow(shadow), .live(live)
    );

    sio_win_decode #(.NPORT(NPORT), .WIN_W(WIN_W)) u_decode (
        .live(live), .io_addr(io_addr), .cs(port_cs), .off(port_off)
    );

    sio_irq_route #(.NPORT(NPORT)) u_route (
        .live(live), .uart_irq(uart_irq), .irq_out(irq_out)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_act
        assign port_active[g] = live[g].en;

        // R6: a chip select never comes from a port that is down
        a_r6_cs_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
            port_cs[g] |-> port_active[g]);
    end

    // R8: never more than one chip select
    a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_cs));
    // R7: nothing selected means a zero offset
    a_r7_off_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (port_cs == '0) |-> (port_off == '0));
    // R9: interrupt number zero has no line behind it
    a_r9_line0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out[0]);
endmodule

// File: tb/sio_serial_res_bench.sv
module sio_serial_res_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, cfg_commit;
    logic [7:0]  cfg_dev, cfg_idx, cfg_data;
    logic [15:0] io_addr;
    logic [1:0]  uart_irq;
    logic [1:0]  port_cs, port_active;
    logic [2:0]  port_off;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sio_serial_res u_sio_serial_res (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dev(cfg_dev),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .cfg_commit(cfg_commit),
        .io_addr(io_addr), .uart_irq(uart_irq), .port_cs(port_cs),
        .port_off(port_off), .port_active(port_active), .irq_out(irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d, logic [7:0] i, logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dev = d; cfg_idx = i; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_port(int p, logic [7:0] en, logic [15:0] base, logic [3:0] irq);
        wr(8'(4 + p), 8'h30, en);
        wr(8'(4 + p), 8'h60, base[15:8]);
        wr(8'(4 + p), 8'h61, base[7:0]);
        wr(8'(4 + p), 8'h70, {4'hA, irq});   // high nibble must be ignored
    endtask

    // leaves the bench at the negedge after the teardown edge
    task automatic commit_first();
        @(negedge clk); cfg_commit = 1'b1;
        @(negedge clk); cfg_commit = 1'b0;
    endtask

    task automatic commit_full();
        commit_first();
        @(negedge clk);
    endtask

    function automatic logic hitf(logic en, logic [15:0] b, logic [15:0] x);
        return en && ({1'b0, x} >= {1'b0, b}) && ({1'b0, x} < ({1'b0, b} + 17'd8));
    endfunction

    task automatic sweep(string req, logic e0, logic [15:0] b0, logic e1, logic [15:0] b1);
        for (int s = 0; s < 2; s++) begin
            for (int k = -4; k < 12; k++) begin
                logic [15:0] a;
                logic h0, h1;
                logic [1:0] ecs;
                logic [2:0] eoff;
                a  = 16'(int'(s == 0 ? b0 : b1) + k);
                h0 = hitf(e0, b0, a);
                h1 = hitf(e1, b1, a);
                ecs  = {h1 && !h0, h0};
                eoff = h0 ? 3'(a - b0) : (h1 ? 3'(a - b1) : 3'd0);
                @(negedge clk); io_addr = a; #1;
                check({req, " cs"},  32'(port_cs),  32'(ecs));
                check({req, " R7 off"}, 32'(port_off), 32'(eoff));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_commit = 1'b0;
        cfg_dev = '0; cfg_idx = '0; cfg_data = '0; io_addr = '0; uart_irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        uart_irq = 2'b11; #1;
        // R11: reset state
        check("R11 active", 32'(port_active), 0);
        check("R11 cs", 32'(port_cs), 0);
        check("R11 irq", 32'(irq_out), 0);
        // R11: shadow zero -> a bare commit enables nothing
        commit_full();
        check("R11 shadow zero", 32'(port_active), 0);

        // R3: programmed but not committed
        set_port(0, 8'h01, 16'h03F8, 4'd4);
        set_port(1, 8'h80, 16'h02F8, 4'd3);
        repeat (4) @(negedge clk);
        check("R3 no commit active", 32'(port_active), 0);
        sweep("R3 no commit", 1'b0, 16'h03F8, 1'b0, 16'h02F8);

        // R1 R2 R6: commit brings both up
        commit_full();
        check("R2 both up", 32'(port_active), 32'h3);
        sweep("R6 R1 base", 1'b1, 16'h03F8, 1'b1, 16'h02F8);

        // R1: foreign devices and registers
        wr(8'h03, 8'h60, 8'h12); wr(8'h06, 8'h61, 8'h00);
        wr(8'h04, 8'h62, 8'h55); wr(8'h05, 8'h31, 8'h00);
        wr(8'h00, 8'h30, 8'h00);
        commit_full();
        check("R1 foreign active", 32'(port_active), 32'h3);
        sweep("R1 foreign", 1'b1, 16'h03F8, 1'b1, 16'h02F8);

        // R2: zero enable takes port 1 down
        wr(8'h05, 8'h30, 8'h00);
        commit_full();
        check("R2 port1 down", 32'(port_active), 32'h1);
        sweep("R2 down", 1'b1, 16'h03F8, 1'b0, 16'h02F8);

        // R8: overlap
        set_port(0, 8'h01, 16'h0100, 4'd4);
        set_port(1, 8'h01, 16'h0104, 4'd3);
        commit_full();
        sweep("R8 overlap", 1'b1, 16'h0100, 1'b1, 16'h0104);

        // R6: top of address space, no wrap
        set_port(0, 8'h01, 16'hFFF8, 4'd4);
        set_port(1, 8'h01, 16'h0000, 4'd3);
        commit_full();
        sweep("R6 top", 1'b1, 16'hFFF8, 1'b1, 16'h0000);

        // R4 R5: base change on port 0, port 1 unchanged
        set_port(0, 8'h01, 16'h03F8, 4'd4);
        commit_first();
        io_addr = 16'hFFF9; #1;
        check("R4 gap port0", 32'(port_active), 32'h2);
        check("R4 gap no cs", 32'(port_cs), 0);
        check("R5 port1 kept", 32'(port_active[1]), 1);
        @(negedge clk); io_addr = 16'h03FA; #1;
        check("R4 applied", 32'(port_active), 32'h3);
        check("R4 new base cs", 32'(port_cs), 32'h1);
        check("R4 new base off", 32'(port_off), 2);

        // R4: irq-only change on port 1 also tears down
        wr(8'h05, 8'h70, 8'h09);
        commit_first(); #1;
        check("R4 irq gap", 32'(port_active), 32'h1);
        @(negedge clk); #1;
        check("R4 irq applied", 32'(port_active), 32'h3);

        // R4: enabling an inactive port waits for the second edge
        wr(8'h05, 8'h30, 8'h00); commit_full();
        wr(8'h05, 8'h30, 8'h01);
        commit_first(); #1;
        check("R4 enable waits", 32'(port_active), 32'h1);
        @(negedge clk); #1;
        check("R4 enable done", 32'(port_active), 32'h3);

        // R10: commit held into the apply cycle is ignored
        wr(8'h04, 8'h61, 8'hE8);
        @(negedge clk); cfg_commit = 1'b1;
        @(negedge clk);
        @(negedge clk); cfg_commit = 1'b0; #1;
        check("R10 applied", 32'(port_active), 32'h3);
        io_addr = 16'h03EB; #1;
        check("R10 new base", 32'(port_cs), 32'h1);
        @(negedge clk); #1;
        check("R10 stays", 32'(port_active), 32'h3);

        // R9: every interrupt pairing, every request pattern
        for (int i0 = 0; i0 < 16; i0++) begin
            for (int i1 = 0; i1 < 16; i1++) begin
                wr(8'h04, 8'h70, 8'(i0));
                wr(8'h05, 8'h70, 8'(i1));
                commit_full();
                for (int u = 0; u < 4; u++) begin
                    logic [15:0] exp;
                    exp = '0;
                    if (i0 != 0 && u[0]) exp[i0] = 1'b1;
                    if (i1 != 0 && u[1]) exp[i1] = 1'b1;
                    uart_irq = 2'(u); #1;
                    check("R9 route", 32'(irq_out), 32'(exp));
                end
            end
        end

        // R9: inactive port routes nothing
        wr(8'h05, 8'h70, 8'h05); wr(8'h04, 8'h70, 8'h06);
        wr(8'h05, 8'h30, 8'h00);
        commit_full();
        uart_irq = 2'b11; #1;
        check("R9 inactive quiet", 32'(irq_out), 32'h0040);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule